// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave

This block is the digital core of a three-wire serial memory slave. It holds 1024 words of 16 bits. A master selects it with `cs`, clocks it on `clk`, sends commands on `sdi` and receives data on `sdo`. Every command opens with a 1 start bit, then carries a two-bit op-code and a 10-bit word address, all sampled on rising clock edges. A read returns one leading 0, then the addressed word, most significant bit first. As long as select stays high, the read carries on through the following addresses with no gap. A write carries 16 data bits after the address.

Writes pass only when the write-enable latch is set. Reset clears the latch, and only the two control commands change it. After a write has been accepted, dropping select starts a fixed programming delay. When select goes high again, the output reports busy (0) or ready (1) until the next start bit is taken. The `sdo_oe` output tells the pad when to drive `sdo`. When it is low, the line is released to high impedance.

Top module: `mwr_eeprom_slave`

## Requirements
- R1: While reset is asserted, and after it, `sdo_oe` is 0 and the write-enable latch is clear. A reset clears a latch that was set, so a later WRITE leaves the array unchanged.
- R2: With `cs` high, bits are sampled on the rising edge of `clk`. Leading 0 bits are skipped. The first 1 is the start bit, followed by a 2-bit op-code (READ=10, WRITE=01, control=00) and a 10-bit address, MSB first.
- R3: On READ, `sdo` is 0 in the cycle after the last address bit (`sdo_oe`=1). The 16 bits of the addressed word follow MSB first, one per rising edge.
- R4: While `cs` stays high, the bit after a word's LSB is the MSB of the word at the next address, with no 0 between them. Address 1023 is followed by address 0.
- R5: Control op-code 00 with address bits [9:8]=11 sets the write-enable latch, and with [9:8]=00 clears it. Other values of [9:8] leave the latch as it is. Address bits [7:0] are don't-care.
- R6: A WRITE with the latch set stores the 16 bits that follow the address (MSB first) at that address.
- R7: A WRITE with the latch clear leaves the array unchanged and starts no busy/ready report.
- R8: READ returns the stored data whether the latch is set or clear.
- R9: After an accepted WRITE, the first rising edge with `cs` low starts a PROG_CYCLES-cycle delay. With `cs` high, `sdo_oe`=1 and `sdo` shows 0 while the delay runs and 1 once it ends. A start bit is ignored during the delay. An accepted start bit ends the report.
- R10: With `cs` low, `sdo_oe` is 0. A rising edge with `cs` low aborts any command in progress, so a partial WRITE stores nothing. The next start bit begins a fresh command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; inputs sampled and output changed on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cs | input | 1 | Chip select, active high |
| sdi | input | 1 | Serial command, address and data input |
| sdo | output | 1 | Serial data or busy/ready status output |
| sdo_oe | output | 1 | Drive enable for `sdo`; 0 means the pin is released |

## Verification
On every cycle, the assertions check these properties:
- the output is released whenever select is low;
- select low returns the command logic to idle;
- the leading 0 of a read;
- the busy status reads 0;
- the programming delay begins only after select has dropped;
- no start bit is taken while it runs;
- the enable latch moves only at a command decode;
- the array is written only in a write's data phase with the latch set.

The data itself can only be shown by the bench's scenarios. These cover the words returned MSB first, the gap-free sequential stream and its wrap from 1023 to 0, and writes that are ignored while the latch is clear or after a reset. They also cover the control codes that change nothing, aborted writes, and the point at which busy turns to ready.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_WDATA = 3'd2,
        ST_READ  = 3'd3,
        ST_DRAIN = 3'd4
    } mwr_state_e;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_CTRL  = 2'b00;

    localparam logic [1:0] CTRL_ENABLE  = 2'b11;
    localparam logic [1:0] CTRL_DISABLE = 2'b00;

endpackage

// File: rtl/mwr_word_array.sv
module mwr_word_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Non-volatile contents: no reset on the storage.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/mwr_read_stream.sv
module mwr_read_stream #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              active,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic              bit_o
);
    localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [ADDR_W-1:0] addr;
        logic [BC_W-1:0]   bcnt;
        logic              out;
    } strm_t;

    strm_t s_q, s_d;

    assign raddr = load ? load_addr : s_q.addr;
    assign bit_o = s_q.out;

    always_comb begin
        s_d = s_q;
        if (load) begin
            // leading zero goes out first, word waits in the shifter
            s_d.sh   = rdata;
            s_d.addr = load_addr + ADDR_W'(1);
            s_d.bcnt = '0;
            s_d.out  = 1'b0;
        end else if (active) begin
            s_d.out = s_q.sh[DATA_W-1];
            if (s_q.bcnt == LAST_BIT) begin
                // LSB leaves now; next word follows without a gap
                s_d.sh   = rdata;
                s_d.addr = s_q.addr + ADDR_W'(1);
                s_d.bcnt = '0;
            end else begin
                s_d.sh   = {s_q.sh[DATA_W-2:0], 1'b0};
                s_d.bcnt = s_q.bcnt + BC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/mwr_prog_timer.sv
module mwr_prog_timer #(
    parameter int PROG_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic cs,
    input  logic clear,
    output logic busy,
    output logic status
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic          arm;
        logic [CW-1:0] cnt;
        logic          status;
    } tmr_t;

    tmr_t t_q, t_d;

    assign busy   = (t_q.cnt != '0);
    assign status = t_q.status;

    always_comb begin
        t_d = t_q;
        if (commit) begin
            t_d.arm = 1'b1;
        end
        if (!cs && t_q.arm) begin
            t_d.arm    = 1'b0;
            t_d.cnt    = CW'(PROG_CYCLES);
            t_d.status = 1'b1;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - CW'(1);
        end
        if (clear) begin
            t_d.status = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

endmodule

// File: rtl/mwr_eeprom_slave.sv
module mwr_eeprom_slave
    import mwr_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    localparam int CMD_W = 2 + ADDR_W;
    localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W = $clog2(MAXB + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        mwr_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] dat;
        logic              wen;
    } fsm_t;

    fsm_t r_q, r_d;

    logic              start_ok;
    logic              rd_load;
    logic              mem_we;
    logic              commit;
    logic [CMD_W-1:0]  cmd_shift;
    logic [DATA_W-1:0] dat_shift;
    logic [1:0]        cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [ADDR_W-1:0] wr_addr;

    logic              busy;
    logic              status;
    logic              rd_bit;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    logic in_idle, in_cmd, in_wdata, in_read, wen_q;

    assign in_idle  = (r_q.state == ST_IDLE);
    assign in_cmd   = (r_q.state == ST_CMD);
    assign in_wdata = (r_q.state == ST_WDATA);
    assign in_read  = (r_q.state == ST_READ);
    assign wen_q    = r_q.wen;
    assign wr_addr  = r_q.cmd[ADDR_W-1:0];

    always_comb begin
        r_d       = r_q;
        start_ok  = 1'b0;
        rd_load   = 1'b0;
        mem_we    = 1'b0;
        commit    = 1'b0;
        cmd_shift = {r_q.cmd[CMD_W-2:0], sdi};
        dat_shift = {r_q.dat[DATA_W-2:0], sdi};
        cmd_op    = cmd_shift[CMD_W-1 -: 2];
        cmd_addr  = cmd_shift[ADDR_W-1:0];

        if (!cs) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
        end else begin
            case (r_q.state)
                ST_IDLE: begin
                    if (sdi && !busy) begin
                        start_ok  = 1'b1;
                        r_d.state = ST_CMD;
                        r_d.cnt   = '0;
                    end
                end
                ST_CMD: begin
                    r_d.cmd = cmd_shift;
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                    if (r_q.cnt == CMD_LAST) begin
                        r_d.cnt = '0;
                        case (cmd_op)
                            OP_READ: begin
                                rd_load   = 1'b1;
                                r_d.state = ST_READ;
                            end
                            OP_WRITE: begin
                                r_d.state = ST_WDATA;
                            end
                            OP_CTRL: begin
                                if (cmd_addr[ADDR_W-1 -: 2] == CTRL_ENABLE) begin
                                    r_d.wen = 1'b1;
                                end else if (cmd_addr[ADDR_W-1 -: 2] == CTRL_DISABLE) begin
                                    r_d.wen = 1'b0;
                                end
                                r_d.state = ST_DRAIN;
                            end
                            default: begin
                                r_d.state = ST_DRAIN;
                            end
                        endcase
                    end
                end
                ST_WDATA: begin
                    r_d.dat = dat_shift;
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                    if (r_q.cnt == DATA_LAST) begin
                        mem_we    = r_q.wen;
                        commit    = r_q.wen;
                        r_d.cnt   = '0;
                        r_d.state = ST_DRAIN;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.cmd   <= '0;
            r_q.dat   <= '0;
            r_q.wen   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    mwr_word_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata (dat_shift),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    mwr_read_stream #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rd_load),
        .load_addr (cmd_addr),
        .active    (cs && in_read),
        .rdata     (rd_data),
        .raddr     (rd_addr),
        .bit_o     (rd_bit)
    );

    mwr_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .cs     (cs),
        .clear  (start_ok),
        .busy   (busy),
        .status (status)
    );

    assign sdo_oe = cs && (in_read || status);
    assign sdo    = in_read ? rd_bit : !busy;

endmodule

// File: rtl/mwr_eeprom_checker.sv
module mwr_eeprom_checker (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic sdo,
    input logic sdo_oe,
    input logic in_idle,
    input logic in_cmd,
    input logic in_wdata,
    input logic in_read,
    input logic busy,
    input logic status,
    input logic wen_q,
    input logic mem_we
);

    a_r10_release_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sdo_oe);

    a_r10_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> in_idle);

    a_r3_dummy_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_read) && cs) |-> (sdo_oe && !sdo));

    a_r9_busy_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && status && busy) |-> (sdo_oe && !sdo));

    a_r9_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_idle) |=> !in_cmd);

    a_r9_delay_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(cs));

    a_r5_latch_moves_on_decode: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wen_q) |-> $past(in_cmd));

    a_r6_write_in_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (in_wdata && cs && wen_q));

endmodule

bind mwr_eeprom_slave mwr_eeprom_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .in_idle  (in_idle),
    .in_cmd   (in_cmd),
    .in_wdata (in_wdata),
    .in_read  (in_read),
    .busy     (busy),
    .status   (status),
    .wen_q    (wen_q),
    .mem_we   (mem_we)
);

// File: tb/mwr_eeprom_slave_test.sv
module mwr_eeprom_slave_test;

    localparam int PROG = 24;

    // {address[25:16], data[15:0]}
    localparam logic [25:0] VEC [8] = '{
        {10'd0,    16'hA5A5},
        {10'd1,    16'h5A5A},
        {10'd1022, 16'hFFFF},
        {10'd1023, 16'h0001},
        {10'd512,  16'h8000},
        {10'd341,  16'h1234},
        {10'd682,  16'hFEDC},
        {10'd3,    16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic di = 1'b0;
    logic sdo, sdo_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] model [1024];
    logic model_wen = 1'b0;

    always #4 clk = ~clk;

    mwr_eeprom_slave #(
        .ADDR_W      (10),
        .DATA_W      (16),
        .PROG_CYCLES (PROG)
    ) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs     (cs),
        .sdi    (di),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        cs = 1'b1;
        di = b;
        @(posedge clk);
    endtask

    task automatic deselect();
        @(negedge clk);
        cs = 1'b0;
        di = 1'b0;
        @(posedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [9:0] a);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 9; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic write_word(input logic [9:0] a, input logic [15:0] d);
        send_cmd(2'b01, a);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
        deselect();
        if (model_wen) model[a] = d;
    endtask

    task automatic ctrl(input logic [1:0] sel);
        send_cmd(2'b00, {sel, 8'h5C});
        deselect();
        if (sel == 2'b11) model_wen = 1'b1;
        else if (sel == 2'b00) model_wen = 1'b0;
    endtask

    task automatic wait_prog();
        repeat (PROG + 3) @(posedge clk);
    endtask

    task automatic read_words(input logic [9:0] a, input int n, input string tag);
        logic [15:0] got;
        logic [9:0]  aw;
        send_cmd(2'b10, a);
        @(negedge clk);
        check(sdo_oe && !sdo, {tag, " R3 leading zero"}, {30'd0, sdo_oe, sdo}, 32'h2);
        @(posedge clk);
        for (int w = 0; w < n; w++) begin
            got = '0;
            for (int b = 0; b < 16; b++) begin
                @(negedge clk);
                got = {got[14:0], sdo};
                @(posedge clk);
            end
            aw = a + 10'(w);
            check(got == model[aw], {tag, " word"}, {16'd0, got}, {16'd0, model[aw]});
        end
        deselect();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [9:0]  a;
        logic [15:0] d;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!sdo_oe, "R1 oe during reset", {31'd0, sdo_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cs = 1'b1;
        #1;
        check(!sdo_oe, "R1 oe after reset with cs high", {31'd0, sdo_oe}, 32'd0);
        deselect();

        // Table walk: R6 write, R9 busy/ready, R3 read-back
        ctrl(2'b11);
        for (int i = 0; i < 8; i++) begin
            a = VEC[i][25:16];
            d = VEC[i][15:0];
            write_word(a, d);
            @(negedge clk);
            cs = 1'b1;
            di = 1'b0;
            #1;
            check(sdo_oe && !sdo, "R9 busy status", {30'd0, sdo_oe, sdo}, 32'h2);
            repeat (PROG + 2) @(posedge clk);
            @(negedge clk);
            check(sdo_oe && sdo, "R9 ready status", {30'd0, sdo_oe, sdo}, 32'h3);
            read_words(a, 1, "R6 table");
        end

        // R10: output released when deselected
        @(negedge clk);
        #1;
        check(!sdo_oe, "R10 oe with cs low", {31'd0, sdo_oe}, 32'd0);

        // R4: sequential stream with wrap 1022,1023,0,1
        read_words(10'd1022, 4, "R4 wrap stream");
        read_words(10'd0, 2, "R4 stream from 0");

        // R2: leading zeros before start bit
        send_bit(1'b0);
        send_bit(1'b0);
        send_bit(1'b0);
        read_words(10'd341, 1, "R2 leading zeros");

        // R7/R8: latch clear, write ignored, read still works
        ctrl(2'b00);
        write_word(10'd0, 16'h0F0F);
        @(negedge clk);
        cs = 1'b1;
        #1;
        check(!sdo_oe, "R7 no status after ignored write", {31'd0, sdo_oe}, 32'd0);
        deselect();
        read_words(10'd0, 1, "R7 R8 ignored write");

        // R5: control code 01 with latch clear keeps it clear
        ctrl(2'b01);
        write_word(10'd1, 16'h0BAD);
        read_words(10'd1, 1, "R5 code 01 keeps clear");

        // R5: control code 10 with latch set keeps it set
        ctrl(2'b11);
        ctrl(2'b10);
        write_word(10'd1, 16'h0BAD);
        wait_prog();
        read_words(10'd1, 1, "R5 code 10 keeps set");

        // R9: start bit ignored while busy
        write_word(10'd512, 16'h8001);
        send_bit(1'b1);
        @(negedge clk);
        di = 1'b0;
        #1;
        check(sdo_oe && !sdo, "R9 start ignored while busy", {30'd0, sdo_oe, sdo}, 32'h2);
        repeat (PROG + 2) @(posedge clk);
        @(negedge clk);
        check(sdo_oe && sdo, "R9 ready after delay", {30'd0, sdo_oe, sdo}, 32'h3);
        read_words(10'd512, 1, "R9 data after delay");

        // R10: aborted write stores nothing, no status
        send_cmd(2'b01, 10'd3);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        deselect();
        @(negedge clk);
        cs = 1'b1;
        #1;
        check(!sdo_oe, "R10 no status after abort", {31'd0, sdo_oe}, 32'd0);
        deselect();
        read_words(10'd3, 1, "R10 aborted write");

        // R1: reset clears a set latch
        write_word(10'd5, 16'h1111);
        wait_prog();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_wen = 1'b0;
        write_word(10'd5, 16'h2222);
        wait_prog();
        read_words(10'd5, 1, "R1 reset clears latch");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule